// File: doc/BRIEF.md
# Bit-Serial Column-Sum Multiplier

This block multiplies two unsigned operands. It produces one bit of the product on each clock by adding the partial products that share a column, together with the carries left over from the previous column. A one-cycle pulse on `start` loads both operands in parallel. The multiplicand register then shifts one bit per clock, least significant first. The multiplier operand stays in a holding register for the whole run. Each column bit enters the top of the result register, which shifts right, so after the last column the whole product sits in place with bit 0 at the bottom.

A chain of full adders, one per multiplier bit above bit 0, does the column addition. Each adder has its own one-bit carry flop. A short delay line keeps the multiplicand bits that have already left the shift register. Once the real multiplicand bits are used up, zeros shift in, so the upper columns and the last carries drain into the result. A small controller counts the columns and raises `stop` when the product is complete. It keeps `stop` high and the result frozen until the next accepted `start`.

Top module: `bsmul_top`

## Requirements
- R1: When `stop` is high, `c` equals the unsigned product `a*b` of the operands sampled with the accepted `start`, for every operand pair including 0, 1 and 255.
- R2: If `start` is sampled high at clock edge E0 while the block is idle or finished, `stop` is low after edges E0 through E16 and first reads high after edge E17.
- R3: While `stop` is high and no new `start` is accepted, `stop` stays high and `c` does not change.
- R4: A `start` that arrives while a multiplication is in progress is ignored: the result and the completion timing match the original operands and the original start.
- R5: With `rst` (synchronous, active high) sampled high at an edge, `c` is 0 and `stop` is 0 after that edge, and any run in progress is abandoned.
- R6: Changes on `a` and `b` after the load edge have no effect on the result of the running multiplication.
- R7: After an accepted `start`, `c` reads 0 and `stop` reads 0 from the load edge until columns begin to shift in.
- R8: Product bits arrive least significant first: after column edge Ek (k = 1 to 16), `c >> (16-k)` equals the product modulo 2^k.
- R9: A `start` accepted while `stop` is high begins a new multiplication with the new operands, with the same timing as R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load-and-go pulse, honoured only when idle or finished |
| a | input | 8 | Multiplicand, consumed serially from bit 0 |
| b | input | 8 | Multiplier, held for the whole run |
| c | output | 16 | Product register, filled from the top, shifting right |
| stop | output | 1 | High once the product is complete |

## Verification
The edge that samples `start` is E0. Column edges E1 to E16 each add one bit, and `stop` rises at E17. The bench drives inputs and samples outputs on the falling edge. After each column edge it reads the partial product in the top k bits. It checks that `stop` is still low after E16, and then expects `stop` and the full product exactly one falling edge later. The hold checks repeat over several idle cycles after completion. The ignored-start and operand-scramble checks still expect the result of the original operands at the original E17.

// File: rtl/bsmul_pkg.sv
package bsmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FLAG = 2'd2,
    ST_DONE = 2'd3
  } bsmul_state_e;
endpackage

// File: rtl/bsmul_ctrl.sv
module bsmul_ctrl
  import bsmul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic stop
);
  localparam int COLS = 2 * W;
  localparam int CW   = $clog2(COLS);
  localparam logic [CW-1:0] LAST = CW'(COLS - 1);

  bsmul_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic          stop_q;

  assign load = start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign step = (state_q == ST_RUN);
  assign stop = stop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      stop_q  <= 1'b0;
    end else if (load) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      stop_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (cnt_q == LAST) state_q <= ST_FLAG;
          else               cnt_q   <= cnt_q + CW'(1);
        end
        ST_FLAG: begin
          state_q <= ST_DONE;
          stop_q  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R4: a running count advances by one each cycle, whatever start does
  assert_run_not_restarted_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && cnt_q != LAST) |=>
      (state_q == ST_RUN && cnt_q == $past(cnt_q) + CW'(1)));

  // R2: stop rises on the edge after the last column
  assert_stop_after_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FLAG) |=> stop_q);

  // R3: stop holds until an accepted start
  assert_stop_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !start) |=> stop_q);
endmodule

// File: rtl/bsmul_colsum.sv
module bsmul_colsum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         col_bit
);
  logic [W-1:0] ra_q;
  logic [W-1:0] rb_q;
  logic [W-2:0] dly_q;
  logic [W-2:0] cy_q;
  logic [W-1:0] taps;
  logic [W-1:0] pp;
  logic [W-1:0] s;
  logic [W-2:0] co;

  assign taps = {dly_q, ra_q[0]};
  assign pp   = rb_q & taps;
  assign s[0] = pp[0];

  for (genvar j = 1; j < W; j++) begin : g_fa
    assign {co[j-1], s[j]} = {1'b0, s[j-1]} + {1'b0, pp[j]} + {1'b0, cy_q[j-1]};
  end

  assign col_bit = s[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_q  <= '0;
      rb_q  <= '0;
      dly_q <= '0;
      cy_q  <= '0;
    end else if (load) begin
      ra_q  <= a_in;
      rb_q  <= b_in;
      dly_q <= '0;
      cy_q  <= '0;
    end else if (step) begin
      ra_q  <= ra_q >> 1;
      dly_q <= taps[W-2:0];
      cy_q  <= co;
    end
  end

  // R6: the multiplier operand is only replaced by a load
  assert_b_held_R6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(rb_q));

  // R6: the multiplicand register only ever loses bits while stepping
  assert_a_drains_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> ($countones(ra_q) <= $countones($past(ra_q))));
endmodule

// File: rtl/bsmul_result.sv
module bsmul_result #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic           col_bit,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [PW-1:0] rc_q;

  always_ff @(posedge clk) begin
    if (rst || load) rc_q <= '0;
    else if (step)   rc_q <= {col_bit, rc_q[PW-1:1]};
  end

  assign prod = rc_q;

  // R8: each step moves the previous contents down one place
  assert_shift_right_R8: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (rc_q[PW-2:0] == $past(rc_q[PW-1:1])));
endmodule

// File: rtl/bsmul_top.sv
module bsmul_top #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] c,
  output logic           stop
);
  logic load;
  logic step;
  logic col_bit;

  bsmul_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .step(step), .stop(stop)
  );

  bsmul_colsum #(.W(W)) u_colsum (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .a_in(a), .b_in(b), .col_bit(col_bit)
  );

  bsmul_result #(.W(W)) u_result (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .col_bit(col_bit), .prod(c)
  );

  // R5: reset clears both outputs
  assert_reset_clears_R5: assert property (@(posedge clk)
    rst |=> (c == '0 && !stop));

  // R3: the product is frozen while stop holds
  assert_c_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> $stable(c));

  // R7: a load clears the product and drops stop
  assert_load_clears_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> (c == '0 && !stop));
endmodule

// File: tb/bsmul_top_tb.sv
module bsmul_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  a = '0;
  logic [7:0]  b = '0;
  logic [15:0] c;
  logic        stop;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bsmul_top #(.W(8)) u_dut (
    .clk(clk), .rst(rst), .start(start), .a(a), .b(b), .c(c), .stop(stop)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One multiplication. Returns after edge E17 at the falling edge.
  // mode: 0 plain, 1 check LSB-first order, 2 inject start mid-run, 3 scramble operands
  task automatic do_op(input logic [7:0] x, input logic [7:0] y, input int mode);
    logic [15:0] p = 16'(x) * 16'(y);
    @(negedge clk);
    a = x; b = y; start = 1'b1;
    @(negedge clk);                    // after E0
    start = 1'b0;
    check(c == 16'd0 && !stop, "R7", int'(c), 0);
    if (mode == 3) begin a = ~x; b = y ^ 8'h5a; end
    for (int k = 1; k <= 16; k++) begin
      if (mode == 2 && k == 5) begin a = 8'd3; b = 8'd7; start = 1'b1; end
      @(negedge clk);                  // after Ek
      start = 1'b0;
      if (mode == 1) check((c >> (16 - k)) == (p & 16'((32'd1 << k) - 1)),
                           "R8", int'(c >> (16 - k)), int'(p & 16'((32'd1 << k) - 1)));
      if (mode == 3 && k == 8) a = 8'hff;
    end
    check(!stop, "R2", int'(stop), 0);
    @(negedge clk);                    // after E17
    check(stop, "R2", int'(stop), 1);
    check(c == p, (mode == 2) ? "R4" : (mode == 3) ? "R6" : "R1", int'(c), int'(p));
  endtask

  task automatic t_reset();
    check(c == 16'd0 && !stop, "R5", int'({c, stop}), 0);
    do_op(8'd13, 8'd11, 0);
    @(negedge clk); a = 8'd200; b = 8'd200; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(c == 16'd0 && !stop, "R5", int'({c, stop}), 0);
    repeat (20) @(negedge clk);
    check(c == 16'd0 && !stop, "R5", int'({c, stop}), 0);
  endtask

  task automatic t_corners();
    logic [7:0] v[3] = '{8'd0, 8'd1, 8'd255};
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) do_op(v[i], v[j], 0);
    do_op(8'd128, 8'd128, 0);
    do_op(8'haa, 8'h55, 0);
  endtask

  task automatic t_order();
    do_op(8'd255, 8'd255, 1);
    do_op(8'd37, 8'd201, 1);
  endtask

  task automatic t_ignore();
    do_op(8'd99, 8'd250, 2);
  endtask

  task automatic t_scramble();
    do_op(8'd171, 8'd19, 3);
  endtask

  task automatic t_hold();
    logic [15:0] p = 16'd77 * 16'd45;
    do_op(8'd77, 8'd45, 0);
    a = 8'd1; b = 8'd2;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(stop && c == p, "R3", int'(c), int'(p));
    end
  endtask

  task automatic t_restart();
    do_op(8'd6, 8'd7, 0);
    do_op(8'd250, 8'd3, 0);            // accepted while stop high
    check(c == 16'd750, "R9", int'(c), 750);
  endtask

  task automatic t_random();
    for (int n = 0; n < 150; n++) do_op(8'($urandom), 8'($urandom), (n % 4));
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_corners();
    t_order();
    t_ignore();
    t_scramble();
    t_hold();
    t_restart();
    t_random();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule